// File: doc/BRIEF.md
# Walking-One Memory Pattern Engine

The engine sweeps a range of memory words with a data pattern that holds a single set bit per word. In write mode it drives one write request per word onto a synchronous request port. In check mode it reads each word back and compares the returned value with the pattern word it regenerates. A check pass ends at the first word that differs, and the address of that word is reported. The position of the set bit does not rotate by one per word. After each word it advances by one plus a slice of the word's byte address, so higher regions of memory shift the bit in larger or zero-sized steps. This exposes coupling between data lines and address regions that a uniform rotation would not reach.

A controller issues a command with a start address, a byte size and a mode, then waits for the one-cycle completion pulse. It first runs a write pass over a region and then a check pass over the same region. After the check pass, the fail flag and the latched address, expected word and actual word describe the first mismatch, if one was found.

Top module: `walkbit_mem_engine`

## Requirements
- R1: During reset and after it is released, `done`, `fail`, `busy` and `mem_req_valid` are 0.
- R2: The word for pass position k is `1 << idx` with `WORD_W` bits, where idx is 0 for the first word of every pass, whatever earlier passes did.
- R3: After the word at byte address A, the index becomes `(idx + 1 + (A >> STEP_SHIFT)) mod WORD_W`. A step of zero, when `(A >> 7) mod 32 == 31`, repeats the same bit.
- R4: The engine visits word addresses in ascending order with a stride of `WORD_W/8` bytes. It starts at `cmd_start` with its low two bits forced to zero, and visits every address strictly below that aligned start plus `cmd_size`. A size of 0 issues no request.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid, and its address, write flag and data do not change.
- R6: `mem_req_write` is 1 for write passes (`cmd_check`=0) and 0 for check passes. For a read accepted at a clock edge, `mem_rdata` is compared at the following edge. At most one read is outstanding at a time.
- R7: A check pass ends at the first mismatching word and issues no further request. It sets `fail` and latches that word's address in `fail_addr`, the regenerated word in `fail_expected` and the read value in `fail_actual`.
- R8: `done` is high for exactly one cycle at the end of every pass, whether the pass ends on a mismatch, at the end of the range, or at once for size 0. `busy` is 0 in that cycle.
- R9: A `cmd_go` while `busy` is 1 is ignored. The running pass continues unchanged.
- R10: `fail` and the failure fields hold their values until the next accepted command. `fail` clears when a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe, taken when idle |
| cmd_start | input | ADDR_W | Start byte address |
| cmd_size | input | ADDR_W | Range size in bytes |
| cmd_check | input | 1 | 0 = write pass, 1 = check pass |
| busy | output | 1 | A pass is running |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word byte address |
| mem_req_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, one cycle after acceptance |
| done | output | 1 | One-cycle end-of-pass pulse |
| fail | output | 1 | Last check pass found a mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatching word |
| fail_expected | output | WORD_W | Regenerated word at that address |
| fail_actual | output | WORD_W | Word read at that address |

## Verification
The bench builds the engine with its default parameters: a 32-bit address, 32-bit words and an index step taken from byte-address bits above bit 7. With these values, small regions near address 0 step the bit by one. A region starting at 0x100 steps it by three. A region straddling 0x2000 includes words whose step is zero and words where the index wraps past 31. Stalls on the ready input and injected corruptions in the bench's memory model cover request holding, first-mismatch reporting and early termination.

// File: rtl/walkbit_mem_engine.sv
module walkbit_mem_engine #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int STEP_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [ADDR_W-1:0] cmd_start,
  input  logic [ADDR_W-1:0] cmd_size,
  input  logic              cmd_check,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [WORD_W-1:0] fail_expected,
  output logic [WORD_W-1:0] fail_actual
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int BYTES = WORD_W / 8;
  localparam int LSB   = $clog2(BYTES);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RESP} state_t;

  state_t            st;
  logic              chk_mode;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W:0]   end_addr;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] exp_word;

  logic [WORD_W-1:0] pat_word;
  logic [ADDR_W:0]   nxt_addr;
  logic              more;
  logic [IDX_W-1:0]  nxt_idx;
  logic [ADDR_W-1:0] start_al;
  logic              accept;

  assign pat_word = WORD_W'(1) << idx;
  assign nxt_addr = {1'b0, cur_addr} + (ADDR_W+1)'(BYTES);
  assign more     = nxt_addr < end_addr;
  assign nxt_idx  = idx + IDX_W'(1) + IDX_W'(cur_addr >> STEP_SHIFT);
  assign start_al = {cmd_start[ADDR_W-1:LSB], {LSB{1'b0}}};
  assign accept   = cmd_go && (st == S_IDLE);

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_write = !chk_mode;
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = pat_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      chk_mode      <= 1'b0;
      cur_addr      <= '0;
      end_addr      <= '0;
      idx           <= '0;
      exp_word      <= '0;
      done          <= 1'b0;
      fail          <= 1'b0;
      fail_addr     <= '0;
      fail_expected <= '0;
      fail_actual   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          chk_mode <= cmd_check;
          cur_addr <= start_al;
          end_addr <= {1'b0, start_al} + {1'b0, cmd_size};
          idx      <= '0;
          fail     <= 1'b0;
          if (cmd_size == '0) done <= 1'b1;
          else                st   <= S_REQ;
        end
        S_REQ: if (mem_req_ready) begin
          if (chk_mode) begin
            exp_word <= pat_word;
            st       <= S_RESP;
          end else begin
            cur_addr <= nxt_addr[ADDR_W-1:0];
            idx      <= nxt_idx;
            if (!more) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        S_RESP: begin
          if (mem_rdata != exp_word) begin
            fail          <= 1'b1;
            fail_addr     <= cur_addr;
            fail_expected <= exp_word;
            fail_actual   <= mem_rdata;
            st            <= S_IDLE;
            done          <= 1'b1;
          end else begin
            cur_addr <= nxt_addr[ADDR_W-1:0];
            idx      <= nxt_idx;
            if (more) st <= S_REQ;
            else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !done && !fail && !mem_req_valid);

  assert_write_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> $countones(mem_req_wdata) == 1);

  assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[LSB-1:0] == '0);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_wdata) && $stable(mem_req_write));

  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_write |=> !mem_req_valid);

  assert_fail_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done && !mem_req_valid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  assert_fail_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_go |=> $stable(fail) && $stable(fail_addr));
endmodule

// File: tb/sim_walkbit_mem_engine.sv
module sim_walkbit_mem_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_go = 1'b0;
  logic [31:0] cmd_start = '0;
  logic [31:0] cmd_size = '0;
  logic        cmd_check = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [31:0] mem_rdata;
  logic        done;
  logic        fail;
  logic [31:0] fail_addr;
  logic [31:0] fail_expected;
  logic [31:0] fail_actual;

  always #5 clk = ~clk;

  walkbit_mem_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_start(cmd_start),
    .cmd_size(cmd_size), .cmd_check(cmd_check), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_expected(fail_expected),
    .fail_actual(fail_actual)
  );

  // memory model, request log and corruption port
  logic [31:0] mem [0:255];
  logic [31:0] log_addr [0:255];
  logic [31:0] log_data [0:255];
  logic        log_wr [0:255];
  int          log_n;
  logic        log_clr = 1'b0;
  logic        poke_en = 1'b0;
  logic [31:0] poke_addr = '0;
  logic [31:0] poke_val = '0;
  logic        stall_on = 1'b0;
  logic [7:0]  lfsr = 8'h5a;

  assign mem_req_ready = stall_on ? lfsr[0] : 1'b1;

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (log_clr) log_n <= 0;
    if (poke_en) mem[poke_addr[9:2]] <= poke_val;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else               mem_rdata <= mem[mem_req_addr[9:2]];
      if (!log_clr && log_n < 256) begin
        log_addr[log_n] <= mem_req_addr;
        log_data[log_n] <= mem_req_wdata;
        log_wr[log_n]   <= mem_req_write;
        log_n           <= log_n + 1;
      end
    end
  end

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input logic [31:0] start, input int k);
    logic [31:0] i = 0;
    logic [31:0] a = start;
    for (int n = 0; n < k; n++) begin
      i = (i + 1 + (a >> 7)) % 32;
      a = a + 4;
    end
    return 32'h1 << i;
  endfunction

  task automatic clear_log();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_val = v;
    @(negedge clk) poke_en = 1'b0;
  endtask

  task automatic issue(input logic [31:0] s, input logic [31:0] z, input bit c);
    @(negedge clk);
    cmd_go = 1'b1; cmd_start = s; cmd_size = z; cmd_check = c;
    @(negedge clk) cmd_go = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done, req, 32'(done), 32'd1);
    check(!busy, "R8 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    check(!done, "R8 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic verify_writes(input logic [31:0] s, input int words, input string req);
    int bad = 0;
    check(log_n == words, {req, " request count"}, 32'(log_n), 32'(words));
    for (int k = 0; k < words && k < log_n; k++)
      if (log_addr[k] != s + 32'(4*k) || log_data[k] != model_word(s, k) || !log_wr[k]) bad++;
    check(bad == 0, {req, " address/data sequence"}, 32'(bad), 32'd0);
    check(log_n > 0 && log_data[0] == 32'h1, "R2 first word index 0", log_data[0], 32'h1);
  endtask

  task automatic t_reset();
    check(!done && !fail && !busy && !mem_req_valid, "R1 reset outputs",
          {28'd0, done, fail, busy, mem_req_valid}, 32'd0);
  endtask

  task automatic t_write_basic();
    clear_log();
    issue(32'h0, 32'h40, 1'b0);
    wait_done("R8 write done");
    verify_writes(32'h0, 16, "R2 R4 unit-step write");
  endtask

  task automatic t_write_step_stall();
    stall_on = 1'b1;
    clear_log();
    issue(32'h100, 32'h100, 1'b0);
    wait_done("R8 stalled write done");
    verify_writes(32'h100, 64, "R3 R5 step-three write with stalls");
    stall_on = 1'b0;
  endtask

  task automatic t_write_zero_step();
    clear_log();
    issue(32'h1F80, 32'h100, 1'b0);
    wait_done("R8 write done");
    verify_writes(32'h1F80, 64, "R3 zero step and wrap");
    check(log_data[1] == log_data[0], "R3 zero step repeats bit", log_data[1], log_data[0]);
  endtask

  task automatic t_check_pass();
    stall_on = 1'b1;
    clear_log();
    issue(32'h100, 32'h100, 1'b1);
    wait_done("R6 check done");
    check(!fail, "R6 clean check passes", 32'(fail), 32'd0);
    check(log_n == 64, "R6 read count", 32'(log_n), 32'd64);
    check(log_wr[0] == 1'b0, "R6 reads in check mode", 32'(log_wr[0]), 32'd0);
    stall_on = 1'b0;
  endtask

  task automatic t_check_fail();
    logic [31:0] good5 = model_word(32'h1F80, 5);
    poke(32'h1F80 + 20, good5 ^ 32'h8000_0001);
    poke(32'h1F80 + 36, 32'h0);
    clear_log();
    issue(32'h1F80, 32'h100, 1'b1);
    wait_done("R7 check done on mismatch");
    check(fail, "R7 fail set", 32'(fail), 32'd1);
    check(fail_addr == 32'h1F94, "R7 first failing address", fail_addr, 32'h1F94);
    check(fail_expected == good5, "R7 expected word", fail_expected, good5);
    check(fail_actual == (good5 ^ 32'h8000_0001), "R7 actual word", fail_actual, good5 ^ 32'h8000_0001);
    check(log_n == 6, "R7 stops at first mismatch", 32'(log_n), 32'd6);
    repeat (10) @(negedge clk);
    check(log_n == 6 && !mem_req_valid, "R7 no requests after failure", 32'(log_n), 32'd6);
    check(fail && fail_addr == 32'h1F94, "R10 result held", fail_addr, 32'h1F94);
    poke(32'h1F80 + 20, good5);
    poke(32'h1F80 + 36, model_word(32'h1F80, 9));
  endtask

  task automatic t_size_zero();
    clear_log();
    issue(32'h40, 32'h0, 1'b1);
    check(done, "R8 size zero done at once", 32'(done), 32'd1);
    check(!fail, "R10 fail cleared by new command", 32'(fail), 32'd0);
    @(negedge clk);
    check(!done, "R8 done single cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    check(log_n == 0, "R4 size zero issues nothing", 32'(log_n), 32'd0);
  endtask

  task automatic t_odd_size();
    clear_log();
    issue(32'h3, 32'h0A, 1'b0);
    wait_done("R8 odd size done");
    verify_writes(32'h0, 3, "R4 unaligned start and partial size");
  endtask

  task automatic t_busy_ignore();
    stall_on = 1'b1;
    clear_log();
    issue(32'h0, 32'h40, 1'b0);
    repeat (3) @(negedge clk);
    cmd_go = 1'b1; cmd_start = 32'h200; cmd_size = 32'h4; cmd_check = 1'b1;
    @(negedge clk) cmd_go = 1'b0;
    wait_done("R9 write done");
    verify_writes(32'h0, 16, "R9 command while busy ignored");
    repeat (3) @(negedge clk);
    check(log_n == 16, "R9 no second pass", 32'(log_n), 32'd16);
    stall_on = 1'b0;
  endtask

  bit wd_fired = 1'b0;
  initial begin
    #1500000;
    wd_fired = 1'b1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    log_n = 0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_write_step_stall();
    t_write_zero_step();
    t_check_pass();
    t_check_fail();
    t_size_zero();
    t_odd_size();
    t_busy_ignore();
    if (!wd_fired) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule